// File: doc/BRIEF.md
# Circular SPI Message Queue Sequencer

This block steps through a window of a command/data buffer that software has filled, and hands the entries one at a time to an SPI frame engine without processor help. The window is set by a start pointer and an end pointer, and it may run around the top of the buffer through entry 0. While the sequencer runs, it holds `running` high and presents `msg_ptr`. The frame engine reads the command and transmit words at that index. It pulses `frame_done` when the entry has been shifted out, and its received word is written back at the same index while `rx_wr_en` is high.

When the last entry of the window completes, the sequencer does one of two things. In wrap mode it returns to the start pointer. Otherwise it halts. A stop request never cuts an entry or a queue pass short. It is held pending and honoured only when the end pointer's entry completes. Three single-cycle event pulses report:
- each completed entry,
- each end-of-queue,
- each halt caused by a stop request.

Top module: `spi_queue_seq`

## Requirements
- R1: After reset, `running`, `stop_pending`, `msg_ptr`, `qstart_ptr`, `qend_ptr`, `wrap_mode` and all three event outputs are 0.
- R2: A `start_cmd` seen while idle sets `running` in the next cycle and loads `msg_ptr` with the start pointer held before that edge.
- R3: A `frame_done` while running on an entry other than the end pointer advances `msg_ptr` by one modulo `DEPTH`, so a start pointer above the end pointer runs through entry 0.
- R4: A `frame_done` on the end pointer's entry with `wrap_mode` = 1 and no stop request reloads `msg_ptr` with the start pointer and keeps `running` high.
- R5: A `frame_done` on the end pointer's entry with `wrap_mode` = 0 clears `running`.
- R6: A `stop_req` pulse while running sets `stop_pending`, which stays high until the end pointer's entry completes. At that completion `running` and `stop_pending` clear and `evt_stopped` pulses for one cycle. A `stop_req` arriving in that same completing cycle counts.
- R7: Every `frame_done` while running gives a one-cycle `evt_msg_sent` pulse in the following cycle.
- R8: `evt_end_queue` pulses for one cycle after the end pointer's entry completes, in both wrap modes.
- R9: `start_cmd` while running has no effect on `msg_ptr` or `running`.
- R10: Writes to the start pointer, end pointer and wrap mode take effect in the next cycle only while idle and are dropped while running. Only the low log2(`DEPTH`) bits of a pointer are kept.
- R11: `rx_wr_en` is high in exactly the cycles where `frame_done` is high while running. A `frame_done` while idle produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_start_we | input | 1 | Write strobe for the queue start pointer |
| cfg_start_ptr | input | 7 | New queue start pointer |
| cfg_end_we | input | 1 | Write strobe for the queue end pointer |
| cfg_end_ptr | input | 7 | New queue end pointer |
| cfg_wrap_we | input | 1 | Write strobe for wrap mode |
| cfg_wrap | input | 1 | New wrap mode value (1 = restart at start pointer) |
| start_cmd | input | 1 | Start pulse |
| stop_req | input | 1 | Stop request pulse |
| frame_done | input | 1 | Frame engine finished the current entry |
| msg_ptr | output | 7 | Index of the entry being sent |
| rx_wr_en | output | 1 | Write strobe for the receive entry at `msg_ptr` |
| running | output | 1 | Sequencer active; request to the frame engine |
| stop_pending | output | 1 | Stop request waiting for end of queue |
| qstart_ptr | output | 7 | Stored start pointer |
| qend_ptr | output | 7 | Stored end pointer |
| wrap_mode | output | 1 | Stored wrap mode |
| evt_msg_sent | output | 1 | Entry-completed pulse |
| evt_end_queue | output | 1 | End-of-queue pulse |
| evt_stopped | output | 1 | Halted-on-stop-request pulse |

## Verification
The bench builds the block with `DEPTH` = 16, so each pointer keeps 4 bits.

A small depth lets a queue run from entry 14 through 15 and 0 to entry 1 in a few frames, which checks the modulo advance and the wrap return. The same width means a pointer write of 0x13 must read back as 3, which checks the masking. Short queues of two to three entries make it cheap to place a stop request early, mid-queue, and on the completing cycle of the last entry.

// File: rtl/spi_queue_pkg.sv
package spi_queue_pkg;
  localparam int unsigned PTR_BITS = 7;

  typedef struct packed {
    logic sent;
    logic eoq;
    logic stopped;
  } seq_evt_t;
endpackage

// File: rtl/spi_queue_cfg.sv
module spi_queue_cfg #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             lock,
  input  logic             start_we,
  input  logic [IDX_W-1:0] start_val,
  input  logic             end_we,
  input  logic [IDX_W-1:0] end_val,
  input  logic             wrap_we,
  input  logic             wrap_val,
  output logic [IDX_W-1:0] qsp,
  output logic [IDX_W-1:0] qep,
  output logic             wrap
);
  logic [IDX_W-1:0] qsp_d, qep_d;
  logic             wrap_d;

  always_comb begin
    qsp_d  = qsp;
    qep_d  = qep;
    wrap_d = wrap;
    if (!lock) begin
      if (start_we) qsp_d  = start_val;
      if (end_we)   qep_d  = end_val;
      if (wrap_we)  wrap_d = wrap_val;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      qsp  <= '0;
      qep  <= '0;
      wrap <= 1'b0;
    end else begin
      qsp  <= qsp_d;
      qep  <= qep_d;
      wrap <= wrap_d;
    end
  end
endmodule

// File: rtl/spi_queue_ptr.sv
module spi_queue_ptr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] cur,
  input  logic [IDX_W-1:0] qep,
  output logic [IDX_W-1:0] nxt,
  output logic             at_end
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_comb begin
    if (cur == LAST) nxt = '0;
    else             nxt = cur + 1'b1;
    at_end = (cur == qep);
  end
endmodule

// File: rtl/spi_queue_ctrl.sv
module spi_queue_ctrl
  import spi_queue_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start_cmd,
  input  logic             stop_req,
  input  logic             frame_done,
  input  logic             at_end,
  input  logic             wrap,
  input  logic [IDX_W-1:0] qsp,
  input  logic [IDX_W-1:0] ptr_inc,
  output logic [IDX_W-1:0] ptr_q,
  output logic             run_q,
  output logic             pend_q,
  output seq_evt_t         evt_q
);
  logic [IDX_W-1:0] ptr_d;
  logic             run_d, pend_d;
  seq_evt_t         evt_d;

  always_comb begin
    ptr_d  = ptr_q;
    run_d  = run_q;
    pend_d = pend_q;
    evt_d  = '0;
    if (!run_q) begin
      if (start_cmd) begin
        run_d = 1'b1;
        ptr_d = qsp;
      end
    end else begin
      if (stop_req) pend_d = 1'b1;
      if (frame_done) begin
        evt_d.sent = 1'b1;
        if (at_end) begin
          evt_d.eoq = 1'b1;
          if (pend_q || stop_req) begin
            run_d         = 1'b0;
            pend_d        = 1'b0;
            evt_d.stopped = 1'b1;
          end else if (wrap) begin
            ptr_d = qsp;
          end else begin
            run_d = 1'b0;
          end
        end else begin
          ptr_d = ptr_inc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      evt_q  <= '0;
    end else begin
      ptr_q  <= ptr_d;
      run_q  <= run_d;
      pend_q <= pend_d;
      evt_q  <= evt_d;
    end
  end
endmodule

// File: rtl/spi_queue_seq.sv
module spi_queue_seq
  import spi_queue_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_start_we,
  input  logic [PTR_BITS-1:0] cfg_start_ptr,
  input  logic                cfg_end_we,
  input  logic [PTR_BITS-1:0] cfg_end_ptr,
  input  logic                cfg_wrap_we,
  input  logic                cfg_wrap,
  input  logic                start_cmd,
  input  logic                stop_req,
  input  logic                frame_done,
  output logic [PTR_BITS-1:0] msg_ptr,
  output logic                rx_wr_en,
  output logic                running,
  output logic                stop_pending,
  output logic [PTR_BITS-1:0] qstart_ptr,
  output logic [PTR_BITS-1:0] qend_ptr,
  output logic                wrap_mode,
  output logic                evt_msg_sent,
  output logic                evt_end_queue,
  output logic                evt_stopped
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni_q;
  logic [IDX_W-1:0] qsp, qep, ptr_q, ptr_inc;
  logic             wrap, at_end, run_q, pend_q;
  seq_evt_t         evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni_q = rst_sync_q[1];

  spi_queue_cfg #(.IDX_W(IDX_W)) u_cfg (
    .clk       (clk),
    .rst_ni    (rst_ni_q),
    .lock      (run_q),
    .start_we  (cfg_start_we),
    .start_val (cfg_start_ptr[IDX_W-1:0]),
    .end_we    (cfg_end_we),
    .end_val   (cfg_end_ptr[IDX_W-1:0]),
    .wrap_we   (cfg_wrap_we),
    .wrap_val  (cfg_wrap),
    .qsp       (qsp),
    .qep       (qep),
    .wrap      (wrap)
  );

  spi_queue_ptr #(.DEPTH(DEPTH)) u_ptr (
    .cur    (ptr_q),
    .qep    (qep),
    .nxt    (ptr_inc),
    .at_end (at_end)
  );

  spi_queue_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_ni     (rst_ni_q),
    .start_cmd  (start_cmd),
    .stop_req   (stop_req),
    .frame_done (frame_done),
    .at_end     (at_end),
    .wrap       (wrap),
    .qsp        (qsp),
    .ptr_inc    (ptr_inc),
    .ptr_q      (ptr_q),
    .run_q      (run_q),
    .pend_q     (pend_q),
    .evt_q      (evt_q)
  );

  assign msg_ptr       = PTR_BITS'(ptr_q);
  assign qstart_ptr    = PTR_BITS'(qsp);
  assign qend_ptr      = PTR_BITS'(qep);
  assign wrap_mode     = wrap;
  assign running       = run_q;
  assign stop_pending  = pend_q;
  assign rx_wr_en      = frame_done & run_q;
  assign evt_msg_sent  = evt_q.sent;
  assign evt_end_queue = evt_q.eoq;
  assign evt_stopped   = evt_q.stopped;
endmodule

// File: rtl/spi_queue_seq_chk.sv
module spi_queue_seq_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic       start_cmd,
  input logic       stop_req,
  input logic       frame_done,
  input logic [6:0] msg_ptr,
  input logic       rx_wr_en,
  input logic       running,
  input logic       stop_pending,
  input logic [6:0] qstart_ptr,
  input logic [6:0] qend_ptr,
  input logic       wrap_mode,
  input logic       evt_msg_sent,
  input logic       evt_end_queue,
  input logic       evt_stopped
);
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_cmd && !running) |=> (running && msg_ptr == $past(qstart_ptr))); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_cmd && running && !frame_done) |=> (running && $stable(msg_ptr))); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_ni)
    running |=> ($stable(qstart_ptr) && $stable(qend_ptr) && $stable(wrap_mode))); // R10
  AST_SENT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ni)
    (frame_done && running) |=> evt_msg_sent); // R7
  AST_EOQ_WITH_SENT: assert property (@(posedge clk) disable iff (!rst_ni)
    evt_end_queue |-> evt_msg_sent); // R8
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    evt_stopped |-> (!running && !stop_pending && evt_end_queue)); // R6
  AST_PEND_RUNNING: assert property (@(posedge clk) disable iff (!rst_ni)
    stop_pending |-> running); // R6
  AST_RX_STROBE: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_wr_en |-> (frame_done && running)); // R11
  AST_IDLE_NO_EVT: assert property (@(posedge clk) disable iff (!rst_ni)
    !running |=> !evt_msg_sent); // R11
endmodule

bind spi_queue_seq spi_queue_seq_chk u_chk (
  .clk           (clk),
  .rst_ni        (rst_ni_q),
  .start_cmd     (start_cmd),
  .stop_req      (stop_req),
  .frame_done    (frame_done),
  .msg_ptr       (msg_ptr),
  .rx_wr_en      (rx_wr_en),
  .running       (running),
  .stop_pending  (stop_pending),
  .qstart_ptr    (qstart_ptr),
  .qend_ptr      (qend_ptr),
  .wrap_mode     (wrap_mode),
  .evt_msg_sent  (evt_msg_sent),
  .evt_end_queue (evt_end_queue),
  .evt_stopped   (evt_stopped)
);

// File: tb/test_spi_queue_seq.sv
module test_spi_queue_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DEPTH      = 16;
  localparam int  WD_LIMIT   = 5000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_start_we, cfg_end_we, cfg_wrap_we, cfg_wrap;
  logic [6:0] cfg_start_ptr, cfg_end_ptr;
  logic       start_cmd, stop_req, frame_done;
  logic [6:0] msg_ptr, qstart_ptr, qend_ptr;
  logic       rx_wr_en, running, stop_pending, wrap_mode;
  logic       evt_msg_sent, evt_end_queue, evt_stopped;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_queue_seq #(.DEPTH(DEPTH)) i_spi_queue_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_start_we(cfg_start_we), .cfg_start_ptr(cfg_start_ptr),
    .cfg_end_we(cfg_end_we), .cfg_end_ptr(cfg_end_ptr),
    .cfg_wrap_we(cfg_wrap_we), .cfg_wrap(cfg_wrap),
    .start_cmd(start_cmd), .stop_req(stop_req), .frame_done(frame_done),
    .msg_ptr(msg_ptr), .rx_wr_en(rx_wr_en), .running(running),
    .stop_pending(stop_pending), .qstart_ptr(qstart_ptr), .qend_ptr(qend_ptr),
    .wrap_mode(wrap_mode), .evt_msg_sent(evt_msg_sent),
    .evt_end_queue(evt_end_queue), .evt_stopped(evt_stopped)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WD_LIMIT);
      summary();
    end
  end

  task automatic write_cfg(int sp, int ep, bit wr);
    @(negedge clk);
    cfg_start_we = 1'b1; cfg_start_ptr = 7'(sp);
    cfg_end_we = 1'b1;   cfg_end_ptr = 7'(ep);
    cfg_wrap_we = 1'b1;  cfg_wrap = wr;
    @(negedge clk);
    cfg_start_we = 1'b0; cfg_end_we = 1'b0; cfg_wrap_we = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start_cmd = 1'b1;
    @(negedge clk); start_cmd = 1'b0;
  endtask

  // one completed frame; events sampled in the cycle after frame_done
  task automatic do_frame(string req, bit stop, int exp_ptr_after, bit exp_run,
                          bit exp_eoq, bit exp_stp);
    @(negedge clk); frame_done = 1'b1; stop_req = stop;
    #1 check("R11", "rx_wr_en with done", rx_wr_en, 1);
    @(negedge clk); frame_done = 1'b0; stop_req = 1'b0;
    check("R7", "evt_msg_sent", evt_msg_sent, 1);
    check(req, "msg_ptr after frame", msg_ptr, exp_ptr_after);
    check(req, "running after frame", running, exp_run);
    check("R8", "evt_end_queue", evt_end_queue, exp_eoq);
    check("R6", "evt_stopped", evt_stopped, exp_stp);
    @(negedge clk);
    check("R7", "evt_msg_sent one cycle", evt_msg_sent, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cfg_start_we = 0; cfg_end_we = 0; cfg_wrap_we = 0; cfg_wrap = 0;
    cfg_start_ptr = 0; cfg_end_ptr = 0;
    start_cmd = 0; stop_req = 0; frame_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "running", running, 0);
    check("R1", "stop_pending", stop_pending, 0);
    check("R1", "msg_ptr", msg_ptr, 0);
    check("R1", "qstart/qend/wrap", {qstart_ptr, qend_ptr, wrap_mode}, 0);
    check("R1", "events", {evt_msg_sent, evt_end_queue, evt_stopped}, 0);
  endtask

  task automatic t_single_pass();
    write_cfg(2, 4, 0);
    do_start();
    check("R2", "running after start", running, 1);
    check("R2", "msg_ptr at start", msg_ptr, 2);
    do_frame("R3", 0, 3, 1, 0, 0);
    do_frame("R3", 0, 4, 1, 0, 0);
    do_frame("R5", 0, 4, 0, 1, 0);
  endtask

  task automatic t_wrap_zero();
    write_cfg(14, 1, 1);
    do_start();
    check("R2", "msg_ptr at start 14", msg_ptr, 14);
    do_frame("R3", 0, 15, 1, 0, 0);
    do_frame("R3", 0, 0, 1, 0, 0);
    do_frame("R3", 0, 1, 1, 0, 0);
    do_frame("R4", 0, 14, 1, 1, 0);
  endtask

  task automatic t_stop_pending();
    // still running from t_wrap_zero, at 14
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    check("R6", "stop_pending set", stop_pending, 1);
    do_frame("R6", 0, 15, 1, 0, 0);
    check("R6", "stop_pending held", stop_pending, 1);
    do_frame("R6", 0, 0, 1, 0, 0);
    do_frame("R6", 0, 1, 1, 0, 0);
    do_frame("R6", 0, 1, 0, 1, 1);
    check("R6", "stop_pending cleared", stop_pending, 0);
  endtask

  task automatic t_stop_on_last();
    write_cfg(5, 6, 1);
    do_start();
    do_frame("R3", 0, 6, 1, 0, 0);
    do_frame("R6", 1, 6, 0, 1, 1);
  endtask

  task automatic t_ignored();
    write_cfg(8, 10, 0);
    do_start();
    do_frame("R3", 0, 9, 1, 0, 0);
    @(negedge clk); start_cmd = 1'b1;
    @(negedge clk); start_cmd = 1'b0;
    check("R9", "msg_ptr after start while running", msg_ptr, 9);
    check("R9", "running after start while running", running, 1);
    write_cfg(1, 2, 1);
    check("R10", "qstart blocked", qstart_ptr, 8);
    check("R10", "qend blocked", qend_ptr, 10);
    check("R10", "wrap blocked", wrap_mode, 0);
    do_frame("R3", 0, 10, 1, 0, 0);
    do_frame("R5", 0, 10, 0, 1, 0);
    @(negedge clk); frame_done = 1'b1;
    #1 check("R11", "rx_wr_en idle", rx_wr_en, 0);
    @(negedge clk); frame_done = 1'b0;
    check("R11", "no event when idle", {evt_msg_sent, evt_end_queue, evt_stopped}, 0);
    check("R11", "still idle", running, 0);
  endtask

  task automatic t_mask();
    write_cfg(7'h13, 7'h7e, 1);
    check("R10", "start ptr masked", qstart_ptr, 3);
    check("R10", "end ptr masked", qend_ptr, 14);
    check("R10", "wrap accepted idle", wrap_mode, 1);
  endtask

  initial begin
    t_reset();
    t_single_pass();
    t_wrap_zero();
    t_stop_pending();
    t_stop_on_last();
    t_ignored();
    t_mask();
    done = 1'b1;
    summary();
  end
endmodule